// File: doc/BRIEF.md
# Byte-Wide Memory Bus Splitter with Supply-Fail Guard

This block is the front end of a byte-wide, SRAM-style host bus (active-low chip enable, output enable and write enable, 17-bit byte address). It divides one address space between a small on-chip register file and an external 128K×8 static RAM. The lowest 64 addresses are claimed on chip. The first 14 of these hold timekeeping and control registers, and the remaining 50 are general-purpose user storage. All other addresses reach the external memory. The host chip enable is passed to the external memory for every address. The host output enable is passed only outside the on-chip window, so the external device never drives the data bus while the block answers a read.

A supply-good input stands in for analog voltage monitoring. While it is low, every external enable is forced inactive, and on-chip read and write strobes are suppressed in the same cycle. A registered guard latches the fault at each clock edge. After supply-good returns, the guard keeps access blocked until a clock edge sees the host chip enable inactive. A cycle that began during the fault is therefore never passed through half-finished. Reset arms the same guard.

Top module: `membus_gate`

## Requirements
- R1: When access is allowed, ext_ce_n equals host_ce_n for every address, including the on-chip window.
- R2: The on-chip window is host_addr[16:6] == 0 (addresses 0x00000 to 0x0003F). Inside it, ext_oe_n stays 1 at all times.
- R3: Outside the window, ext_oe_n is 0 exactly when access is allowed, host_ce_n=0, host_oe_n=0 and host_we_n=1.
- R4: Inside the window with access allowed, host_ce_n=0 and host_we_n=0, int_wr is 1. int_addr always equals host_addr[5:0].
- R5: Inside the window with access allowed, host_ce_n=0, host_we_n=1 and host_oe_n=0, int_rd is 1. Otherwise int_rd is 0.
- R6: When host_we_n=0 and host_oe_n=0 together, the cycle is a write. int_rd is 0 and ext_oe_n is 1.
- R7: int_user is 1 exactly when the address is inside the window and host_addr[5:0] >= 14. That gives 50 user locations, 14 to 63. int_user is 0 for offsets 0 to 13 and outside the window.
- R8: With host_ce_n=1, ext_ce_n=1, ext_oe_n=1, int_rd=0 and int_wr=0.
- R9: While supply_ok=0, ext_ce_n=1, ext_oe_n=1, int_rd=0 and int_wr=0 in the same cycle.
- R10: A clock edge that samples supply_ok=0 arms the guard. The guard stays armed, keeping the outputs as in R9, until an edge samples supply_ok=1 with host_ce_n=1. Access is allowed from the cycle after that edge.
- R11: A clock edge that samples rst_n=0 arms the guard exactly as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the guard register |
| rst_n | input | 1 | Synchronous active-low reset, arms the guard |
| supply_ok | input | 1 | High while the supply is within tolerance |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_addr | input | 17 | Host byte address |
| ext_ce_n | output | 1 | Chip enable to the external SRAM, active low |
| ext_oe_n | output | 1 | Output enable to the external SRAM, active low |
| int_rd | output | 1 | On-chip read strobe |
| int_wr | output | 1 | On-chip write strobe |
| int_addr | output | 6 | Offset inside the on-chip window |
| int_user | output | 1 | Offset lies in the user storage range |

## Verification
The bench first probes the window edge at 0x3F and 0x40, plus the top address 0x1FFFF. A decoder with a mis-sized compare would let the external memory drive during an on-chip read, or leave it silent above the window. It then probes the user boundary at offsets 13 and 14, and cycles where write and output enable are asserted together. A wrong priority there would show a read strobe or an open external output enable during a write. Finally, it drops the supply in the middle of an access and restores it while chip enable is still low. A guard that releases on supply alone would pass the tail of that cycle to the external memory. Random traffic with occasional supply dips is checked against a bench model throughout.

// File: rtl/membus_pkg.sv
// Shared types for the byte-wide bus splitter.
// Assumes active-low host strobes; write enable outranks output enable.
package membus_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // Classify one bus cycle from the three host strobes.
    function automatic acc_kind_e classify(input logic ce_n,
                                           input logic oe_n,
                                           input logic we_n);
        if (ce_n)
            return ACC_NONE;
        else if (!we_n)
            return ACC_WRITE;
        else if (!oe_n)
            return ACC_READ;
        else
            return ACC_NONE;
    endfunction

endpackage

// File: rtl/membus_window_decode.sv
// Address window decoder.
// Claims the lowest 2**WIN_BITS addresses for the on-chip register file and
// marks offsets at or above USER_BASE as user storage.
// Assumes ADDR_W > WIN_BITS and USER_BASE < 2**WIN_BITS.
module membus_window_decode #(
    parameter int ADDR_W    = 17,
    parameter int WIN_BITS  = 6,
    parameter int USER_BASE = 14
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                in_win,
    output logic                user,
    output logic [WIN_BITS-1:0] off
);
    localparam int HI_W = ADDR_W - WIN_BITS;
    localparam logic [WIN_BITS-1:0] USER_LO = WIN_BITS'(USER_BASE);

    logic [HI_W-1:0] hi_bits;

    // Split the address into page and offset, and test page zero.
    always_comb begin
        hi_bits = addr[ADDR_W-1:WIN_BITS];
        off     = addr[WIN_BITS-1:0];
        in_win  = (hi_bits == '0);
        user    = in_win && (off >= USER_LO);
    end

endmodule

// File: rtl/membus_guard.sv
// Supply-fail guard.
// Arms on reset or on a sampled supply fault. Disarms only at an edge that
// sees a good supply with the host chip enable idle, so no partial cycle
// is released.
module membus_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic host_ce_n,
    output logic allow
);
    logic armed;

    // Track the fault latch; release needs an idle bus and a good supply.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b1;
        else if (!supply_ok)
            armed <= 1'b1;
        else if (host_ce_n)
            armed <= 1'b0;
    end

    // Grant access only with a live supply and the latch cleared.
    always_comb allow = supply_ok && !armed;

    // R10: an edge that saw a fault keeps the guard shut in the next cycle.
    a_r10_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!supply_ok) |-> !allow);

    // R11: the first cycle after reset is always blocked.
    a_r11_reset_arms: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !allow);

endmodule

// File: rtl/membus_steer.sv
// Strobe steering.
// Routes a classified host cycle either to the on-chip strobes or to the
// external enables, all qualified by the guard's allow signal.
module membus_steer
    import membus_pkg::*;
(
    input  logic allow,
    input  logic in_win,
    input  logic host_ce_n,
    input  logic host_oe_n,
    input  logic host_we_n,
    output logic ext_ce_n,
    output logic ext_oe_n,
    output logic int_rd,
    output logic int_wr
);
    acc_kind_e kind;

    // Reduce the strobes to one access kind with write priority.
    always_comb kind = classify(host_ce_n, host_oe_n, host_we_n);

    // Drive external enables and on-chip strobes from kind and window.
    always_comb begin
        ext_ce_n = !(allow && !host_ce_n);
        ext_oe_n = !(allow && (kind == ACC_READ) && !in_win);
        int_rd   = allow && (kind == ACC_READ) && in_win;
        int_wr   = allow && (kind == ACC_WRITE) && in_win;
    end

endmodule

// File: rtl/membus_gate.sv
// Top of the byte-wide bus splitter.
// Decodes the on-chip window, guards against supply faults and steers host
// strobes to the register file or the external SRAM.
// Assumes the host strobes are already synchronous to clk.
module membus_gate #(
    parameter int ADDR_W    = 17,
    parameter int WIN_BITS  = 6,
    parameter int USER_BASE = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                supply_ok,
    input  logic                host_ce_n,
    input  logic                host_oe_n,
    input  logic                host_we_n,
    input  logic [ADDR_W-1:0]   host_addr,
    output logic                ext_ce_n,
    output logic                ext_oe_n,
    output logic                int_rd,
    output logic                int_wr,
    output logic [WIN_BITS-1:0] int_addr,
    output logic                int_user
);
    logic in_win;
    logic allow;

    membus_window_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .USER_BASE(USER_BASE)
    ) u_decode (
        .addr  (host_addr),
        .in_win(in_win),
        .user  (int_user),
        .off   (int_addr)
    );

    membus_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .host_ce_n(host_ce_n),
        .allow    (allow)
    );

    membus_steer u_steer (
        .allow    (allow),
        .in_win   (in_win),
        .host_ce_n(host_ce_n),
        .host_oe_n(host_oe_n),
        .host_we_n(host_we_n),
        .ext_ce_n (ext_ce_n),
        .ext_oe_n (ext_oe_n),
        .int_rd   (int_rd),
        .int_wr   (int_wr)
    );

    // R2: the external memory never drives on an on-chip address.
    a_r2_oe_quiet_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr[ADDR_W-1:WIN_BITS] == '0) |-> ext_oe_n);

    // R6: a write never opens a read path.
    a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we_n |-> (ext_oe_n && !int_rd));

    // R8: an idle chip enable produces no activity.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        host_ce_n |-> (ext_ce_n && ext_oe_n && !int_rd && !int_wr));

    // R9: a bad supply blocks everything in the same cycle.
    a_r9_supply_block: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (ext_ce_n && ext_oe_n && !int_rd && !int_wr));

    // R4/R5: at most one on-chip strobe at a time.
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_rd, int_wr}));

endmodule

// File: tb/membus_gate_test.sv
module membus_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_ok = 1'b1;
    logic        host_ce_n = 1'b1;
    logic        host_oe_n = 1'b1;
    logic        host_we_n = 1'b1;
    logic [16:0] host_addr = '0;
    logic        ext_ce_n, ext_oe_n, int_rd, int_wr, int_user;
    logic [5:0]  int_addr;

    int checks = 0;
    int failures = 0;
    logic m_armed = 1'b1;

    always #2.5 clk = ~clk;

    membus_gate uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .host_ce_n(host_ce_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
        .host_addr(host_addr), .ext_ce_n(ext_ce_n), .ext_oe_n(ext_oe_n),
        .int_rd(int_rd), .int_wr(int_wr), .int_addr(int_addr), .int_user(int_user)
    );

    // Bench model of the guard latch (R10, R11).
    always @(posedge clk) begin
        if (!rst_n)          m_armed <= 1'b1;
        else if (!supply_ok) m_armed <= 1'b1;
        else if (host_ce_n)  m_armed <= 1'b0;
    end

    function automatic bit f_allow();
        return supply_ok && !m_armed;
    endfunction
    function automatic bit f_win();
        return host_addr[16:6] == 11'd0;
    endfunction
    function automatic bit f_read();
        return !host_ce_n && host_we_n && !host_oe_n;
    endfunction
    function automatic bit f_write();
        return !host_ce_n && !host_we_n;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t addr=%05h ce=%b oe=%b we=%b ok=%b",
                     tag, act, exp, $time, host_addr, host_ce_n, host_oe_n, host_we_n, supply_ok);
        end
    endtask

    // Compare every output with the bench model.
    task automatic check_all();
        bit a = f_allow();
        chk("R1/R8/R9/R10 ext_ce_n", 8'(ext_ce_n), 8'(!(a && !host_ce_n)));
        chk("R2/R3/R6 ext_oe_n", 8'(ext_oe_n), 8'(!(a && f_read() && !f_win())));
        chk("R5/R6 int_rd", 8'(int_rd), 8'(a && f_read() && f_win()));
        chk("R4 int_wr", 8'(int_wr), 8'(a && f_write() && f_win()));
        chk("R4 int_addr", 8'(int_addr), 8'(host_addr[5:0]));
        chk("R7 int_user", 8'(int_user), 8'(f_win() && host_addr[5:0] >= 6'd14));
    endtask

    task automatic step(input bit ok, input bit ce, input bit oe, input bit we,
                        input logic [16:0] ad);
        @(negedge clk);
        supply_ok = ok; host_ce_n = ce; host_oe_n = oe; host_we_n = we; host_addr = ad;
        #1;
        check_all();
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h5EED_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        // R11: during reset all blocked, even with an active read
        step(1, 0, 0, 1, 17'h00100);
        chk("R11 reset ext_ce_n", 8'(ext_ce_n), 8'd1);
        @(negedge clk); rst_n = 1'b1;
        // R11: still armed because CE stayed low at release edge
        step(1, 0, 0, 1, 17'h00100);
        chk("R11 held after reset", 8'(ext_oe_n), 8'd1);
        step(1, 1, 1, 1, 17'h00100);
        step(1, 0, 0, 1, 17'h00100);
        chk("R3 outside read opens oe", 8'(ext_oe_n), 8'd0);
        // R2 boundary
        step(1, 0, 0, 1, 17'h0003F);
        chk("R2 0x3F claimed", 8'(int_rd), 8'd1);
        step(1, 0, 0, 1, 17'h00040);
        chk("R2 0x40 external", 8'(ext_oe_n), 8'd0);
        step(1, 0, 0, 1, 17'h1FFFF);
        // R7 boundary
        step(1, 0, 1, 0, 17'h0000D);
        chk("R7 offset 13 not user", 8'(int_user), 8'd0);
        step(1, 0, 1, 0, 17'h0000E);
        chk("R7 offset 14 user", 8'(int_user), 8'd1);
        // R6 both strobes
        step(1, 0, 0, 0, 17'h00005);
        chk("R6 write wins inside", 8'(int_wr), 8'd1);
        step(1, 0, 0, 0, 17'h10000);
        chk("R6 write wins outside", 8'(ext_oe_n), 8'd1);
        // R1 ce passes in window
        step(1, 0, 1, 1, 17'h00020);
        chk("R1 ce in window", 8'(ext_ce_n), 8'd0);
        // R9/R10 fault mid-cycle
        step(0, 0, 0, 1, 17'h02000);
        chk("R9 fault blocks ce", 8'(ext_ce_n), 8'd1);
        step(1, 0, 0, 1, 17'h02000);
        chk("R10 held ce low", 8'(ext_ce_n), 8'd1);
        step(1, 0, 0, 1, 17'h02000);
        chk("R10 still held", 8'(ext_oe_n), 8'd1);
        step(1, 1, 1, 1, 17'h02000);
        step(1, 0, 0, 1, 17'h02000);
        chk("R10 released", 8'(ext_oe_n), 8'd0);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [16:0] ad;
            int unsigned r = $urandom_range(0, 3);
            if (r == 0)      ad = 17'($urandom_range(0, 63));
            else if (r == 1) ad = 17'($urandom_range(60, 70));
            else             ad = 17'($urandom);
            step($urandom_range(0, 9) != 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0, ad);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule